// File: doc/BRIEF.md
# Compare-Match Output Latch

This block watches a 16-bit timer count supplied from outside and holds three 16-bit compare values. When the timer steps onto a value held in one of the compare registers, that register fires a match event. A match on the set channel drives the low six bits of an 8-bit output latch high. A match on the clear channel drives those same six bits low. A match on the toggle channel inverts the top two bits. Two per-bit masks decide which latch bits each action may reach.

Software can load the whole latch directly at any time. Each channel also keeps a sticky flag that software clears. The timer lives outside the block and tells the block when it has advanced, through `tick_i`.

Top module: `cmp_out_unit`

## Requirements
- R1: After reset the output latch is 0x00, all three flags are 0 and all three compare registers are 0x0000.
- R2: When `cmp_we_i` is high, `cmp_sel_i` picks the register that takes `cmp_wdata_i` at the clock edge: 0 is the set channel, 1 is the clear channel and 2 is the toggle channel. Select value 3 writes nothing.
- R3: A channel matches in a cycle only when `tick_i` is high and `count_i` equals that channel's register. While `tick_i` is low, no match occurs, whatever the count.
- R4: On a set match, each output bit i in 0..5 with `set_en_i[i]`=1 becomes 1 at the clock edge.
- R5: On a clear match, each output bit i in 0..5 with `rt_en_i[i]`=1 becomes 0 at the clock edge.
- R6: On a toggle match, each output bit i in 6..7 with `rt_en_i[i]`=1 inverts at the clock edge.
- R7: When the set and clear channels match in the same cycle, bits enabled for clear become 0. Bits enabled only for set become 1.
- R8: When `out_we_i` is high, the latch loads `out_wdata_i`. For any bit that a match action reaches in the same cycle, the match action wins over the software write.
- R9: A match sets its flag (`flag_o[0]` set, `[1]` clear, `[2]` toggle). The flag stays at 1 until a cycle with the matching `flag_clr_i` bit high and no match. If a match and a clear of the same flag fall in the same cycle, the match wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timer advanced; count_i valid for matching |
| count_i | input | 16 | Timer count |
| cmp_we_i | input | 1 | Compare register write strobe |
| cmp_sel_i | input | 2 | Compare register select |
| cmp_wdata_i | input | 16 | Compare write data |
| set_en_i | input | 6 | Per-bit enable for the set action on bits 0..5 |
| rt_en_i | input | 8 | Per-bit enable for clear (bits 0..5) and toggle (bits 6..7) |
| out_we_i | input | 1 | Software write strobe for the output latch |
| out_wdata_i | input | 8 | Software write data |
| flag_clr_i | input | 3 | Write-one-to-clear for the flags |
| out_o | output | 8 | Output latch |
| flag_o | output | 3 | Match flags |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is a set match and a clear match. The bench gives the set and clear registers the same value and ticks the timer onto it. It uses a clear mask that covers only part of the six bits, and checks that the enabled bits clear while the set-only bits still rise.

The second pair is a software latch write and a match action. The bench drives a write strobe on the same cycle as a set match with a partial set mask. It expects the written value on the unreached bits and the match result on the reached ones. A flag clear that coincides with a new match of the same channel is judged the same way.

// File: rtl/cmp_out_pkg.sv
package cmp_out_pkg;
  localparam int unsigned N_CH = 3;
  typedef enum logic [1:0] {
    CH_SET = 2'd0,
    CH_CLR = 2'd1,
    CH_TOG = 2'd2
  } ch_sel_e;
endpackage

// File: rtl/cmp_chan.sv
module cmp_chan #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             clr_i,
  output logic             match_o,
  output logic             flag_o
);
  logic [CNT_W-1:0] cmp_q;
  logic             flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cmp_q <= '0;
    else if (we_i) cmp_q <= wdata_i;
  end

  assign match_o = tick_i && (count_i == cmp_q);

  // match beats a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_q <= 1'b0;
    else if (match_o)  flag_q <= 1'b1;
    else if (clr_i)    flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  p_flag_on_match_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |=> flag_o);
  p_flag_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);
  p_no_tick_no_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !flag_o) |=> !flag_o);
endmodule

// File: rtl/out_latch.sv
module out_latch #(
  parameter int unsigned SR_W = 6,
  parameter int unsigned TG_W = 2,
  localparam int unsigned OUT_W = SR_W + TG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_hit_i,
  input  logic             clr_hit_i,
  input  logic             tog_hit_i,
  input  logic [SR_W-1:0]  set_en_i,
  input  logic [OUT_W-1:0] rt_en_i,
  input  logic             we_i,
  input  logic [OUT_W-1:0] wdata_i,
  output logic [OUT_W-1:0] q_o
);
  logic [OUT_W-1:0] q_q, q_d;

  for (genvar b = 0; b < SR_W; b++) begin : g_sr
    always_comb begin
      if (clr_hit_i && rt_en_i[b])       q_d[b] = 1'b0;
      else if (set_hit_i && set_en_i[b]) q_d[b] = 1'b1;
      else if (we_i)                     q_d[b] = wdata_i[b];
      else                               q_d[b] = q_q[b];
    end
  end

  for (genvar b = SR_W; b < OUT_W; b++) begin : g_tg
    always_comb begin
      if (tog_hit_i && rt_en_i[b]) q_d[b] = ~q_q[b];
      else if (we_i)               q_d[b] = wdata_i[b];
      else                         q_d[b] = q_q[b];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;

  p_clear_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_hit_i && clr_hit_i) |=> ((q_o[SR_W-1:0] & $past(rt_en_i[SR_W-1:0])) == '0));
  p_clear_bits_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_hit_i |=> ((q_o[SR_W-1:0] & $past(rt_en_i[SR_W-1:0])) == '0));
  p_set_bits_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_hit_i && !clr_hit_i) |=> ((q_o[SR_W-1:0] & $past(set_en_i)) == $past(set_en_i)));
  p_toggle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tog_hit_i |=> ((q_o[OUT_W-1:SR_W] ^ $past(q_o[OUT_W-1:SR_W])) == $past(rt_en_i[OUT_W-1:SR_W])));
  p_hold_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !set_hit_i && !clr_hit_i && !tog_hit_i) |=> $stable(q_o));
endmodule

// File: rtl/cmp_out_unit.sv
module cmp_out_unit
  import cmp_out_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned SR_W  = 6,
  parameter int unsigned TG_W  = 2,
  localparam int unsigned OUT_W = SR_W + TG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             cmp_we_i,
  input  logic [1:0]       cmp_sel_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  input  logic [SR_W-1:0]  set_en_i,
  input  logic [OUT_W-1:0] rt_en_i,
  input  logic             out_we_i,
  input  logic [OUT_W-1:0] out_wdata_i,
  input  logic [N_CH-1:0]  flag_clr_i,
  output logic [OUT_W-1:0] out_o,
  output logic [N_CH-1:0]  flag_o
);
  logic [N_CH-1:0] hit;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic ch_we;
    assign ch_we = cmp_we_i && (cmp_sel_i == 2'(c));
    cmp_chan #(.CNT_W(CNT_W)) i_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (ch_we),
      .wdata_i (cmp_wdata_i),
      .tick_i  (tick_i),
      .count_i (count_i),
      .clr_i   (flag_clr_i[c]),
      .match_o (hit[c]),
      .flag_o  (flag_o[c])
    );
  end

  out_latch #(.SR_W(SR_W), .TG_W(TG_W)) i_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_hit_i (hit[CH_SET]),
    .clr_hit_i (hit[CH_CLR]),
    .tog_hit_i (hit[CH_TOG]),
    .set_en_i  (set_en_i),
    .rt_en_i   (rt_en_i),
    .we_i      (out_we_i),
    .wdata_i   (out_wdata_i),
    .q_o       (out_o)
  );

  p_hit_needs_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |-> (hit == '0));
endmodule

// File: tb/test_cmp_out_unit.sv
module test_cmp_out_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [15:0] count = '0;
  logic        cmp_we = 1'b0;
  logic [1:0]  cmp_sel = '0;
  logic [15:0] cmp_wdata = '0;
  logic [5:0]  set_en = '0;
  logic [7:0]  rt_en = '0;
  logic        out_we = 1'b0;
  logic [7:0]  out_wdata = '0;
  logic [2:0]  flag_clr = '0;
  logic [7:0]  out;
  logic [2:0]  flag;

  cmp_out_unit i_cmp_out_unit (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .count_i(count),
    .cmp_we_i(cmp_we), .cmp_sel_i(cmp_sel), .cmp_wdata_i(cmp_wdata),
    .set_en_i(set_en), .rt_en_i(rt_en), .out_we_i(out_we),
    .out_wdata_i(out_wdata), .flag_clr_i(flag_clr), .out_o(out), .flag_o(flag)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic [7:0] o;
    logic [2:0] f;
    string      tag;
  } exp_t;

  exp_t        sb[$];
  int          n_chk = 0;
  int          n_fail = 0;
  logic [15:0] m_cmp [3];
  logic [7:0]  m_out;
  logic [2:0]  m_flag;

  task automatic check(input logic [7:0] o, input logic [2:0] f, input string tag);
    n_chk++;
    if (out !== o || flag !== f) begin
      n_fail++;
      $display("FAIL %s: out=%h flag=%b expected out=%h flag=%b", tag, out, flag, o, f);
    end
  endtask

  // driver: inputs are already set at a negedge; predict the next edge, push, advance
  task automatic cycle(input string tag);
    logic [2:0] m;
    exp_t e;
    for (int c = 0; c < 3; c++) m[c] = tick && (count == m_cmp[c]);
    for (int b = 0; b < 6; b++) begin
      if (m[1] && rt_en[b])       m_out[b] = 1'b0;
      else if (m[0] && set_en[b]) m_out[b] = 1'b1;
      else if (out_we)            m_out[b] = out_wdata[b];
    end
    for (int b = 6; b < 8; b++) begin
      if (m[2] && rt_en[b]) m_out[b] = ~m_out[b];
      else if (out_we)      m_out[b] = out_wdata[b];
    end
    for (int c = 0; c < 3; c++) begin
      if (m[c])             m_flag[c] = 1'b1;
      else if (flag_clr[c]) m_flag[c] = 1'b0;
    end
    if (cmp_we && cmp_sel != 2'd3) m_cmp[cmp_sel] = cmp_wdata;
    e.o = m_out; e.f = m_flag; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    tick = 1'b0; cmp_we = 1'b0; out_we = 1'b0; flag_clr = '0;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(e.o, e.f, e.tag);
      end
    end
  end

  task automatic wr_cmp(input logic [1:0] s, input logic [15:0] v, input string tag);
    cmp_we = 1'b1; cmp_sel = s; cmp_wdata = v;
    cycle(tag);
  endtask

  task automatic tk(input logic [15:0] v, input string tag);
    tick = 1'b1; count = v;
    cycle(tag);
  endtask

  initial begin
    for (int c = 0; c < 3; c++) m_cmp[c] = '0;
    m_out = '0; m_flag = '0;
    #23;
    check(8'h00, 3'b000, "R1 reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // all registers zero after reset: a tick at count 0 hits every channel
    set_en = 6'h00; rt_en = 8'h00;
    tk(16'h0000, "R1 zero compares");
    flag_clr = 3'b111; cycle("R9 clear all");

    wr_cmp(2'd0, 16'h0010, "R2 write set");
    wr_cmp(2'd1, 16'h0020, "R2 write clr");
    wr_cmp(2'd2, 16'h0030, "R2 write tog");
    wr_cmp(2'd3, 16'h0040, "R2 sel3 write");
    tk(16'h0040, "R2 sel3 ignored");

    set_en = 6'h3F; rt_en = 8'hFF;
    tk(16'h000F, "R3 no equal");
    count = 16'h0010; cycle("R3 equal without tick");
    cycle("R3 count held without tick");
    tk(16'h0010, "R4 set all");
    flag_clr = 3'b001; cycle("R9 clear flag0");

    rt_en = 8'h03;
    tk(16'h0020, "R5 clear masked");
    rt_en = 8'hC0;
    tk(16'h0030, "R6 toggle both");
    rt_en = 8'h40;
    tk(16'h0030, "R6 toggle bit6");
    set_en = 6'h05;
    out_we = 1'b1; out_wdata = 8'h00; cycle("R8 sw write zero");
    tk(16'h0010, "R4 set masked");

    wr_cmp(2'd1, 16'h0010, "R2 clr to same");
    out_we = 1'b1; out_wdata = 8'h00; cycle("R8 sw write");
    set_en = 6'h3F; rt_en = 8'h0F;
    tk(16'h0010, "R7 set and clear");

    out_we = 1'b1; out_wdata = 8'hA5; cycle("R8 sw load");
    wr_cmp(2'd1, 16'h0020, "R2 clr apart");
    set_en = 6'h03; out_we = 1'b1; out_wdata = 8'h00;
    tk(16'h0010, "R8 match beats write");
    flag_clr = 3'b001;
    tk(16'h0010, "R9 match beats clear");
    flag_clr = 3'b111; cycle("R9 clear");
    rt_en = 8'hC0; out_we = 1'b1; out_wdata = 8'h00;
    tk(16'h0030, "R8 toggle beats write");
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #50000;
    n_fail++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule